// File: doc/BRIEF.md
# Watchdog Timer with Overflow and Reset Pulses

This block is an 8-bit up-counter that a chip uses to notice a stalled processor. The counter advances on single-cycle ticks taken from a free-running divider of the peripheral clock. A 3-bit select picks the tick rate. Software arms the timer by writing its configuration and then setting the enable bit. After that it must keep rewriting the counter to zero so the counter never wraps.

In watchdog mode, a wrap from 0xFF to 0x00 sets a sticky overflow flag and drives an overflow output for exactly 64 clocks. If software has enabled it, the wrap also drives an internal reset request for exactly 128 clocks, starting in the same cycle. A second output tells whether that reset should be treated as power-on or manual. In interval mode, a wrap only sets a sticky interval flag and raises an interrupt request for one cycle.

The synchronous active-low reset input stands for the chip's reset pin. It always wins over the watchdog.

Top module: `wdog_timer`

Register map, selected by a 2-bit address:
- Address 0 is control: bit 7 mode (1 = watchdog, 0 = interval), bit 6 interval flag, bit 5 enable, bits 2:0 clock select.
- Address 1 is reset control: bit 7 overflow flag, bit 6 reset enable, bit 5 reset type (1 = manual, 0 = power-on).
- Address 2 is the counter.
- Unused bits read as 0.

## Requirements
- R1: After reset, all three registers read 0x00 and the overflow, reset, manual-type and interrupt outputs are low.
- R2: The counter advances by one per tick, and only while the enable bit (control bit 5) is 1. Clock-select codes 0 to 7 give one tick every 1, 64, 128, 256, 512, 1024, 4096 and 16384 clocks.
- R3: A write to the counter loads the written value and takes priority over a tick in the same cycle. Rewriting 0x00 periodically keeps the overflow output low and the overflow flag at 0.
- R4: In watchdog mode (control bit 7 = 1), a tick with the counter at 0xFF sets the overflow flag (reset-control bit 7). The overflow output is high for exactly 64 clocks, starting the cycle after that tick.
- R5: When reset enable (reset-control bit 6) is 1 at overflow, the reset output rises together with the overflow output and stays high exactly 128 clocks. The manual-type output follows the reset output when reset type (bit 5) is 1 and stays low when it is 0. With reset enable at 0, the reset output stays low.
- R6: In interval mode, overflow sets the interval flag (control bit 6) and raises the interrupt output for exactly one cycle, starting the cycle after the overflow tick. The overflow and reset outputs stay low and the overflow flag stays 0.
- R7: Both flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged.
- R8: A write to the control register while the enable bit is 1 leaves the clock-select field unchanged, including the write that clears the enable bit.
- R9: When the reset input is low at the clock edge where an overflow would occur, the reset wins. The overflow flag reads 0 and no overflow or reset pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset (reset pin) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 8 | Read data, combinational |
| ovf_out | output | 1 | Overflow pulse, 64 clocks |
| rst_out | output | 1 | Internal reset request, 128 clocks |
| rst_manual | output | 1 | High with rst_out when manual reset was selected |
| irq | output | 1 | Interval-mode interrupt, one clock |

## Verification
The assertions assume that the reset input is held low for at least one edge at start-up. They also assume that writes and address changes are settled before the clock edge, so every register update happens exactly at one edge. The bench drives all inputs on the falling edge and holds reset low for several cycles.

The bench lets each pulse run to completion before arming the next overflow. This keeps the retrigger case outside the pulse-length checks, so the 64- and 128-clock windows are measured against a single trigger.

// File: rtl/wdt_pkg.sv
// Shared definitions for the watchdog timer: register addresses, bit
// positions and the clock-select to divider-shift mapping.
package wdt_pkg;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_RSTC  = 2'd1,
        REG_COUNT = 2'd2
    } wdt_reg_e;

    localparam int CTRL_MODE_B = 7;
    localparam int CTRL_ITV_B  = 6;
    localparam int CTRL_EN_B   = 5;
    localparam int RSTC_OVF_B  = 7;
    localparam int RSTC_EN_B   = 6;
    localparam int RSTC_TYPE_B = 5;

    // Log2 of the divide ratio chosen by a clock-select code.
    function automatic int unsigned div_shift(input logic [2:0] cs);
        case (cs)
            3'd0:    return 0;
            3'd1:    return 6;
            3'd2:    return 7;
            3'd3:    return 8;
            3'd4:    return 9;
            3'd5:    return 10;
            3'd6:    return 12;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
// Free-running divider of the peripheral clock. It emits a single-cycle
// tick once every 2**div_shift(sel) clocks.
// Assumes PRE_W >= 14 so the largest ratio fits.
module wdt_prescaler #(
    parameter int PRE_W = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       tick
);
    import wdt_pkg::*;

    logic [PRE_W-1:0] div_q;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] mask;

    // Free-running divider count.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Tick when all bits below the selected ratio are ones.
    always_comb begin
        span = ((PRE_W+1)'(1) << div_shift(sel)) - (PRE_W+1)'(1);
        mask = span[PRE_W-1:0];
        tick = (div_q & mask) == mask;
    end

    // Back-to-back ticks under an unchanged select only at ratio 1.
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $past(tick) && $past(rst_n) && $past(sel) == sel) |-> sel == 3'd0);

endmodule

// File: rtl/wdt_pulse.sv
// Fixed-length pulse generator. A start strobe makes 'active' high for
// exactly LEN cycles, beginning the cycle after the strobe. A new start
// while active restarts the full length.
module wdt_pulse #(
    parameter int LEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] left_q;

    // Remaining-cycle counter for the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)            left_q <= '0;
        else if (start)        left_q <= CW'(LEN);
        else if (left_q != '0) left_q <= left_q - 1'b1;
    end

    assign active = left_q != '0;

    // R4: a pulse only begins after a start strobe.
    p_pulse_from_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(start));

    // R5: the remaining count never exceeds the configured length.
    p_pulse_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= CW'(LEN));

endmodule

// File: rtl/wdog_timer.sv
// Watchdog timer top. It holds the control registers, the up-counter and
// the overflow decision, and drives two pulse generators: overflow output
// and internal reset request. Assumes rst_n is the chip reset pin, is
// synchronous, and wins over any same-edge overflow.
module wdog_timer #(
    parameter int CNT_W   = 8,
    parameter int PRE_W   = 14,
    parameter int OVF_LEN = 64,
    parameter int RST_LEN = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       ovf_out,
    output logic       rst_out,
    output logic       rst_manual,
    output logic       irq
);
    import wdt_pkg::*;

    logic             mode_q, en_q, itv_q;
    logic [2:0]       cs_q;
    logic             ovf_q, rsten_q, rtype_q, type_lat_q;
    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;
    logic             tick;
    logic             wr_ctrl, wr_rstc, wr_cnt;
    logic             ovf_ev, wdt_fire, itv_fire;

    // Register write decode.
    always_comb begin
        wr_ctrl = wr_en && (wr_addr == REG_CTRL);
        wr_rstc = wr_en && (wr_addr == REG_RSTC);
        wr_cnt  = wr_en && (wr_addr == REG_COUNT);
    end

    wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (cs_q),
        .tick (tick)
    );

    // Overflow happens on a tick at all-ones, unless software reloads the counter.
    always_comb begin
        ovf_ev   = en_q && tick && (cnt_q == '1) && !wr_cnt;
        wdt_fire = ovf_ev && mode_q;
        itv_fire = ovf_ev && !mode_q;
    end

    // Control register; clock select is locked while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            en_q   <= 1'b0;
            cs_q   <= 3'd0;
        end else if (wr_ctrl) begin
            mode_q <= wr_data[CTRL_MODE_B];
            en_q   <= wr_data[CTRL_EN_B];
            if (!en_q) cs_q <= wr_data[2:0];
        end
    end

    // Interval flag: set by interval overflow, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                              itv_q <= 1'b0;
        else if (itv_fire)                       itv_q <= 1'b1;
        else if (wr_ctrl && !wr_data[CTRL_ITV_B]) itv_q <= 1'b0;
    end

    // Reset-control options.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsten_q <= 1'b0;
            rtype_q <= 1'b0;
        end else if (wr_rstc) begin
            rsten_q <= wr_data[RSTC_EN_B];
            rtype_q <= wr_data[RSTC_TYPE_B];
        end
    end

    // Overflow flag: set by watchdog overflow, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                               ovf_q <= 1'b0;
        else if (wdt_fire)                        ovf_q <= 1'b1;
        else if (wr_rstc && !wr_data[RSTC_OVF_B]) ovf_q <= 1'b0;
    end

    // Counter: a software load beats a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (wr_cnt)        cnt_q <= wr_data[CNT_W-1:0];
        else if (en_q && tick)  cnt_q <= cnt_q + 1'b1;
    end

    // Interrupt strobe and the reset type latched at firing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q      <= 1'b0;
            type_lat_q <= 1'b0;
        end else begin
            irq_q <= itv_fire;
            if (wdt_fire && rsten_q) type_lat_q <= rtype_q;
        end
    end

    wdt_pulse #(.LEN(OVF_LEN)) u_ovf_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wdt_fire),
        .active(ovf_out)
    );

    wdt_pulse #(.LEN(RST_LEN)) u_rst_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wdt_fire && rsten_q),
        .active(rst_out)
    );

    assign rst_manual = rst_out && type_lat_q;
    assign irq        = irq_q;

    // Read mux.
    always_comb begin
        case (rd_addr)
            REG_CTRL:  rd_data = {mode_q, itv_q, en_q, 2'b00, cs_q};
            REG_RSTC:  rd_data = {ovf_q, rsten_q, rtype_q, 5'b00000};
            REG_COUNT: rd_data = 8'(cnt_q);
            default:   rd_data = 8'h00;
        endcase
    end

    // R4: a watchdog overflow raises the flag and the overflow output.
    p_ovf_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_fire |=> (ovf_q && ovf_out));

    // R5: the reset request only starts together with the overflow pulse.
    p_rst_with_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out) |-> $rose(ovf_out));

    // R6: interval overflow gives an interrupt and no overflow pulse.
    p_itv_no_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        itv_fire |=> (irq && !$rose(ovf_out)));

    // R7: the overflow flag falls only on a write of 0.
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ovf_q) && $past(rst_n)) |-> ($past(wr_rstc) && !$past(wr_data[RSTC_OVF_B])));

    // R8: the clock select is frozen while the timer is enabled.
    p_cs_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_q) && $past(rst_n)) |-> $stable(cs_q));

    // R9: the reset pin clears flag and pulses whatever else happens.
    p_pin_wins_r9: assert property (@(posedge clk)
        !rst_n |=> (!ovf_q && !ovf_out && !rst_out && !irq));

endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       ovf_out, rst_out, rst_manual, irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wdog_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .ovf_out   (ovf_out),
        .rst_out   (rst_out),
        .rst_manual(rst_manual),
        .irq       (irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Write one register; returns at the falling edge after the write edge.
    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        reg_rd(2'd0, v); check("R1 ctrl", v, 0);
        reg_rd(2'd1, v); check("R1 rstc", v, 0);
        reg_rd(2'd2, v); check("R1 count", v, 0);
        check("R1 outputs", {ovf_out, rst_out, rst_manual, irq}, 0);
    endtask

    task automatic t_prescale();
        logic [7:0] v;
        logic [2:0] sels [4] = '{3'd0, 3'd1, 3'd2, 3'd7};
        int ratio [4] = '{1, 64, 128, 16384};
        reg_wr(2'd2, 8'h10);
        repeat (30) @(negedge clk);
        reg_rd(2'd2, v); check("R2 disabled holds", v, 8'h10);
        for (int k = 0; k < 4; k++) begin
            logic [7:0] prev;
            int n;
            reg_wr(2'd2, 8'h00);
            reg_wr(2'd0, 8'h20 | 8'(sels[k]));
            rd_addr = 2'd2;
            #1 prev = rd_data;
            n = 0;
            while (rd_data == prev && n < 40000) begin @(negedge clk); #1; n++; end
            prev = rd_data;
            n = 0;
            while (rd_data == prev && n < 40000) begin @(negedge clk); #1; n++; end
            check($sformatf("R2 tick ratio sel %0d", sels[k]), n, ratio[k]);
            reg_wr(2'd0, 8'h00);
        end
    endtask

    // Arm a watchdog overflow three edges away and measure the pulses.
    task automatic t_fire(input logic [7:0] rstc, input int exp_rst, input int exp_man);
        logic [7:0] v;
        int n_ovf, n_rst, n_man;
        reg_wr(2'd1, rstc);
        reg_wr(2'd2, 8'hFD);
        reg_wr(2'd0, 8'hA0);
        @(negedge clk);
        @(negedge clk);
        check("R4 no early pulse", ovf_out, 0);
        @(negedge clk);
        check("R5 rise together", rst_out, exp_rst != 0 ? 1 : 0);
        n_ovf = 0; n_rst = 0; n_man = 0;
        for (int i = 0; i < 200; i++) begin
            n_ovf += ovf_out; n_rst += rst_out; n_man += rst_manual;
            @(negedge clk);
        end
        reg_wr(2'd0, 8'h00);
        check("R4 overflow length", n_ovf, 64);
        check("R5 reset length", n_rst, exp_rst);
        check("R5 manual type", n_man, exp_man);
        reg_rd(2'd1, v); check("R4 flag set", v, 8'h80 | rstc);
    endtask

    task automatic t_sticky();
        logic [7:0] v;
        reg_wr(2'd1, 8'hC0);
        reg_rd(2'd1, v); check("R7 write 1 keeps flag", v, 8'hC0);
        reg_wr(2'd1, 8'h40);
        reg_rd(2'd1, v); check("R7 write 0 clears flag", v, 8'h40);
        reg_wr(2'd1, 8'h80);
        reg_rd(2'd1, v); check("R7 write 1 does not set", v, 8'h00);
    endtask

    task automatic t_kick();
        logic [7:0] v;
        int seen;
        reg_wr(2'd1, 8'h40);
        reg_wr(2'd2, 8'hF0);
        reg_wr(2'd0, 8'hA0);
        seen = 0;
        for (int k = 0; k < 6; k++) begin
            repeat (10) begin @(negedge clk); seen += ovf_out; end
            reg_wr(2'd2, 8'h00);
            reg_rd(2'd2, v);
            if (k == 0) check("R3 load wins", v, 0);
        end
        reg_wr(2'd0, 8'h00);
        check("R3 no overflow pulse", seen, 0);
        reg_rd(2'd1, v); check("R3 flag clear", v, 8'h40);
    endtask

    task automatic t_interval();
        logic [7:0] v;
        int bad;
        reg_wr(2'd1, 8'h40);
        reg_wr(2'd2, 8'hFD);
        reg_wr(2'd0, 8'h20);
        @(negedge clk);
        @(negedge clk);
        check("R6 irq not early", irq, 0);
        @(negedge clk);
        check("R6 irq high", irq, 1);
        bad = 0;
        @(negedge clk);
        check("R6 irq one cycle", irq, 0);
        for (int i = 0; i < 10; i++) begin
            bad += ovf_out + rst_out;
            @(negedge clk);
        end
        check("R6 no reset pulses", bad, 0);
        reg_rd(2'd0, v); check("R6 interval flag", v, 8'h60);
        reg_rd(2'd1, v); check("R6 overflow flag clear", v, 8'h40);
        reg_wr(2'd0, 8'h00);
        reg_rd(2'd0, v); check("R7 interval flag cleared", v, 8'h00);
    endtask

    task automatic t_cs_lock();
        logic [7:0] v;
        reg_wr(2'd0, 8'h21);
        reg_rd(2'd0, v); check("R8 select while idle", v, 8'h21);
        reg_wr(2'd0, 8'h25);
        reg_rd(2'd0, v); check("R8 select locked", v, 8'h21);
        reg_wr(2'd0, 8'h05);
        reg_rd(2'd0, v); check("R8 disabling write locked", v, 8'h01);
        reg_wr(2'd0, 8'h05);
        reg_rd(2'd0, v); check("R8 select after disable", v, 8'h05);
        reg_wr(2'd0, 8'h00);
    endtask

    task automatic t_pin();
        logic [7:0] v;
        int bad;
        reg_wr(2'd1, 8'h40);
        reg_wr(2'd2, 8'hFD);
        reg_wr(2'd0, 8'hA0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 no overflow pulse", ovf_out, 0);
        check("R9 no reset pulse", rst_out, 0);
        rst_n = 1'b1;
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            bad += ovf_out + rst_out;
        end
        check("R9 quiet after pin reset", bad, 0);
        reg_rd(2'd1, v); check("R9 flag cleared", v, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prescale();
        t_fire(8'h60, 128, 128);
        t_fire(8'h00, 0, 0);
        t_sticky();
        t_fire(8'h40, 128, 0);
        t_kick();
        t_interval();
        t_cs_lock();
        t_pin();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule